// File: doc/BRIEF.md
# Status and Control Register Port over a Two-Wire Serial Bus

This block is the serial-bus end of a small audio control device. It answers as a slave on an I2C bus at a fixed 7-bit address. When the master writes, it sends a register selector byte and then one data byte. The data byte lands in one of two 8-bit control registers, the switch register or the mute/port register, and these drive the rest of the chip. When the master reads, the block skips the selector byte and returns one status byte. That byte carries a power-up flag and the two transmission indicators, stereo and dual, which come in from the detection logic.

The bus lines are sampled in the system clock domain. Each line goes through a two-flop synchronizer and then a three-sample majority vote. After that the block finds the start and stop conditions and the clock edges. It pulls SDA low through an open-drain enable and never drives it high.

The power-up flag is set by reset. It clears once a status byte has been fully clocked out to the master.

Top module: `stsnd_i2c_slave`

## Requirements
- R1: After reset both control registers are 0x00, SDA is released (`sda_oe` = 0) and the power-up flag is 1.
- R2: An address byte whose upper seven bits are 0x5A is acknowledged: SDA is held low during the ninth clock. Any other address gets no acknowledge, and the block ignores the rest of that transfer.
- R3: In a write, selector 0x00 routes the data byte to the switch register and selector 0x01 routes it to the mute/port register. The data byte is acknowledged, and the other register keeps its value.
- R4: Any selector other than 0x00 or 0x01 gets no acknowledge, and neither register changes.
- R5: A register takes its new value only after the data byte has been acknowledged. During the low phase before the ninth clock it still holds the old value.
- R6: A fourth or later byte in a write transfer gets no acknowledge and changes no register.
- R7: A read (R/W bit = 1) returns the status byte with no selector phase, MSB first. Bit 7 is the power-up flag, bit 6 is `stereo_i`, bit 5 is `dual_i`, and bits 4..0 are 0.
- R8: The power-up flag becomes 0 once a status byte has been read through its acknowledge clock. It never becomes 1 again before the next reset.
- R9: A START at any point restarts reception with a new address byte. A partly received byte is discarded.
- R10: A STOP releases SDA and returns the block to idle.
- R11: A pulse on SCL or SDA that lasts a single system clock is ignored. It does not clock a bit, and it does not make a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| stereo_i | input | 1 | Stereo transmission indicator |
| dual_i | input | 1 | Dual sound transmission indicator |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain) |
| sw_reg | output | 8 | Switch register contents |
| mute_reg | output | 8 | Mute/port register contents |

## Verification
Two cases are hard to reach from the ports. One is a START that lands in the middle of a data byte. The other is the window between the eighth data bit and the acknowledge clock, when the register must not yet have changed.

The bench handles the first by calling its START task directly after four data bits. The second is reached by clocking out the eight data bits by hand and sampling the register and the bus line before it raises SCL for the ninth clock. Single-cycle spikes are injected into the low phase of SCL and into the high phase of SDA while a write is in progress. A correct result then shows that the majority filter rejected them.

// File: rtl/stsnd_i2c_slave.sv
module stsnd_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h5A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       stereo_i,
  input  logic       dual_i,
  output logic       sda_oe,
  output logic [7:0] sw_reg,
  output logic [7:0] mute_reg
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} state_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic [2:0] scl_h, sda_h;
  logic       scl_f, sda_f, scl_q, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;

  state_t     state;
  logic [7:0] sr, tx_sr, nb, status;
  logic [3:0] cnt;
  logic [1:0] bidx;
  logic       ack_q, ack_d, rd_q, sel_q, pon;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_h  <= 3'b111;
      sda_h  <= 3'b111;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_h  <= {scl_h[1:0], scl_sy[SYNC_STAGES-1]};
      sda_h  <= {sda_h[1:0], sda_sy[SYNC_STAGES-1]};
      scl_q  <= scl_f;
      sda_q  <= sda_f;
    end
  end

  assign scl_f     = maj3(scl_h);
  assign sda_f     = maj3(sda_h);
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  assign nb     = {sr[6:0], sda_f};
  assign status = {pon, stereo_i, dual_i, 5'b00000};

  always_comb begin
    case (bidx)
      2'd0:    ack_d = (nb[7:1] == DEV_ADDR);
      2'd1:    ack_d = (nb[7:1] == 7'd0);
      2'd2:    ack_d = 1'b1;
      default: ack_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sr       <= '0;
      tx_sr    <= '0;
      cnt      <= '0;
      bidx     <= '0;
      ack_q    <= 1'b0;
      rd_q     <= 1'b0;
      sel_q    <= 1'b0;
      pon      <= 1'b1;
      sda_oe   <= 1'b0;
      sw_reg   <= '0;
      mute_reg <= '0;
    end else if (start_det) begin
      state  <= S_RX;
      cnt    <= '0;
      bidx   <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise) begin
            sr  <= nb;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              ack_q <= ack_d;
              if (bidx == 2'd0) rd_q  <= nb[0];
              if (bidx == 2'd1) sel_q <= nb[0];
            end
          end else if (scl_fall && cnt == 4'd8) begin
            state  <= S_RACK;
            sda_oe <= ack_q;
            cnt    <= '0;
          end
        end
        S_RACK: begin
          if (scl_rise && ack_q && bidx == 2'd2) begin
            if (sel_q) mute_reg <= sr;
            else       sw_reg   <= sr;
          end else if (scl_fall) begin
            cnt <= '0;
            if (!ack_q) begin
              state  <= S_IDLE;
              sda_oe <= 1'b0;
            end else if (bidx == 2'd0 && rd_q) begin
              state  <= S_TX;
              tx_sr  <= status;
              sda_oe <= ~status[7];
            end else begin
              state  <= S_RX;
              sda_oe <= 1'b0;
              bidx   <= bidx + 2'd1;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt != 4'd0) begin
            if (cnt == 4'd8) begin
              state  <= S_TACK;
              sda_oe <= 1'b0;
            end else begin
              tx_sr  <= {tx_sr[6:0], 1'b0};
              sda_oe <= ~tx_sr[6];
            end
          end
        end
        S_TACK: begin
          if (scl_rise) begin
            pon   <= 1'b0;
            ack_q <= ~sda_f;
          end else if (scl_fall) begin
            cnt <= '0;
            if (ack_q) begin
              state  <= S_TX;
              tx_sr  <= status;
              sda_oe <= ~status[7];
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

module stsnd_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic [7:0] sw_reg,
  input logic [7:0] mute_reg,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       pon
);

  // R3
  one_reg_per_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(sw_reg) && !$stable(mute_reg)));

  // R5
  commit_on_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sw_reg) || !$stable(mute_reg)) |-> $past(scl_rise));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R8
  pon_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pon));

  // R2
  oe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

endmodule

bind stsnd_i2c_slave stsnd_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .sw_reg(sw_reg),
  .mute_reg(mute_reg), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .pon(pon)
);

// File: tb/test_stsnd_i2c_slave.sv
module test_stsnd_i2c_slave;
  localparam int H = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, stereo = 1'b1, dual = 1'b0;
  logic sda_oe;
  logic [7:0] sw_reg, mute_reg;
  wire sda_line = sda_m & ~sda_oe;

  stsnd_i2c_slave i_stsnd_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .stereo_i(stereo), .dual_i(dual), .sda_oe(sda_oe),
    .sw_reg(sw_reg), .mute_reg(mute_reg)
  );

  int checks = 0, errors = 0, grace = 0;
  logic [7:0] exp_sw = 8'h00, exp_mute = 8'h00, old_sw = 8'h00, old_mute = 8'h00;
  logic exp_pon = 1'b1;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      if (grace > 0) begin
        grace--;
        chk((sw_reg == exp_sw) || (sw_reg == old_sw), "R3 sw_reg per-clock", sw_reg, exp_sw);
        chk((mute_reg == exp_mute) || (mute_reg == old_mute), "R3 mute_reg per-clock", mute_reg, exp_mute);
      end else begin
        chk(sw_reg == exp_sw, "R3 sw_reg per-clock", sw_reg, exp_sw);
        chk(mute_reg == exp_mute, "R3 mute_reg per-clock", mute_reg, exp_mute);
      end
    end
  end

  task automatic model_set(input bit sel, input logic [7:0] d);
    old_sw   = exp_sw;
    old_mute = exp_mute;
    if (sel) exp_mute = d;
    else     exp_sw   = d;
    grace = 30;
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(H);
    scl = 1'b1; w(H);
    sda_m = 1'b0; w(H);
    scl = 1'b0; w(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(H);
    scl = 1'b1; w(H);
    sda_m = 1'b1; w(H);
  endtask

  task automatic bit_out(input logic b, input bit glitch);
    sda_m = b;
    w(H / 2);
    if (glitch) begin scl = 1'b1; w(1); scl = 1'b0; end
    w(H / 2);
    scl = 1'b1; w(H / 2);
    if (glitch && b) begin sda_m = 1'b0; w(1); sda_m = 1'b1; end
    w(H / 2);
    scl = 1'b0; w(2);
  endtask

  task automatic ack_clk(input logic [7:0] b, input bit commit, input bit sel, output bit ack);
    sda_m = 1'b1; w(H);
    ack = (sda_line == 1'b0);
    if (commit && ack) model_set(sel, b);
    scl = 1'b1; w(H);
    scl = 1'b0; w(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, input bit commit,
                           input bit sel, output bit ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i], glitch);
    ack_clk(b, commit, sel, ack);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(H); scl = 1'b1; w(H / 2);
      v = {v[6:0], sda_line};
      w(H / 2); scl = 1'b0; w(2);
    end
    sda_m = ~mack; w(H);
    scl = 1'b1; w(H);
    scl = 1'b0; w(2);
  endtask

  task automatic read_status(input string req);
    bit a;
    logic [7:0] v;
    logic [7:0] e;
    bus_start();
    send_byte(8'hB5, 1'b0, 1'b0, 1'b0, a);
    chk(a, {req, " read address ack"}, a, 1);
    e = {exp_pon, stereo, dual, 5'b00000};
    recv_byte(1'b0, v);
    bus_stop();
    chk(v == e, {req, " status byte"}, v, e);
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
    exp_pon = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] sub, input logic [7:0] d, input bit glitch,
                           input string req);
    bit a;
    bus_start();
    send_byte(8'hB4, glitch, 1'b0, 1'b0, a);
    chk(a, {req, " address ack"}, a, 1);
    send_byte(sub, glitch, 1'b0, 1'b0, a);
    chk(a, {req, " selector ack"}, a, 1);
    send_byte(d, glitch, 1'b1, sub[0], a);
    chk(a, {req, " data ack"}, a, 1);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    bit a;
    w(5);
    rst_n = 1'b1;
    w(5);
    // R1 reset state
    chk(sw_reg == 8'h00, "R1 sw_reg reset", sw_reg, 0);
    chk(mute_reg == 8'h00, "R1 mute_reg reset", mute_reg, 0);
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    run_cmp = 1'b1;

    // R7 R1 first read shows power-up flag, then R8 cleared
    read_status("R7");
    read_status("R8");
    stereo = 1'b0; dual = 1'b1;
    read_status("R7 dual");

    // R3 both registers
    write_reg(8'h00, 8'h2A, 1'b0, "R3 switch");
    write_reg(8'h01, 8'h15, 1'b0, "R3 mute");
    w(40);
    chk(sw_reg == 8'h2A, "R3 switch value", sw_reg, 8'h2A);
    chk(mute_reg == 8'h15, "R3 mute value", mute_reg, 8'h15);

    // R2 wrong address
    bus_start();
    send_byte(8'hB6, 1'b0, 1'b0, 1'b0, a);
    chk(!a, "R2 foreign address nack", a, 0);
    send_byte(8'h00, 1'b0, 1'b0, 1'b0, a);
    chk(!a, "R2 ignored after foreign address", a, 0);
    send_byte(8'h77, 1'b0, 1'b0, 1'b0, a);
    chk(!a, "R2 ignored data", a, 0);
    bus_stop();
    chk(sw_reg == 8'h2A, "R2 sw unchanged", sw_reg, 8'h2A);

    // R4 bad selector
    bus_start();
    send_byte(8'hB4, 1'b0, 1'b0, 1'b0, a);
    send_byte(8'h02, 1'b0, 1'b0, 1'b0, a);
    chk(!a, "R4 selector 02 nack", a, 0);
    send_byte(8'h99, 1'b0, 1'b0, 1'b0, a);
    chk(!a, "R4 data after bad selector", a, 0);
    bus_stop();
    chk(sw_reg == 8'h2A && mute_reg == 8'h15, "R4 regs unchanged", {sw_reg, mute_reg}, 16'h2A15);

    // R5 no update before the acknowledge clock
    bus_start();
    send_byte(8'hB4, 1'b0, 1'b0, 1'b0, a);
    send_byte(8'h00, 1'b0, 1'b0, 1'b0, a);
    for (int i = 7; i >= 0; i--) bit_out(8'h3C >> i, 1'b0);
    sda_m = 1'b1; w(H - 2);
    chk(sw_reg == 8'h2A, "R5 old value before ack clock", sw_reg, 8'h2A);
    chk(sda_line == 1'b0, "R5 data byte acked", sda_line, 0);
    w(2);
    model_set(1'b0, 8'h3C);
    scl = 1'b1; w(H);
    scl = 1'b0; w(2);
    bus_stop();
    chk(sw_reg == 8'h3C, "R5 new value after ack", sw_reg, 8'h3C);

    // R6 extra byte
    bus_start();
    send_byte(8'hB4, 1'b0, 1'b0, 1'b0, a);
    send_byte(8'h00, 1'b0, 1'b0, 1'b0, a);
    send_byte(8'h55, 1'b0, 1'b1, 1'b0, a);
    chk(a, "R6 third byte acked", a, 1);
    send_byte(8'hAA, 1'b0, 1'b0, 1'b0, a);
    chk(!a, "R6 fourth byte nack", a, 0);
    bus_stop();
    chk(sw_reg == 8'h55, "R6 fourth byte ignored", sw_reg, 8'h55);

    // R9 START in the middle of a data byte
    bus_start();
    send_byte(8'hB4, 1'b0, 1'b0, 1'b0, a);
    send_byte(8'h00, 1'b0, 1'b0, 1'b0, a);
    for (int i = 7; i >= 4; i--) bit_out(8'hF0 >> i, 1'b0);
    bus_start();
    send_byte(8'hB4, 1'b0, 1'b0, 1'b0, a);
    chk(a, "R9 address after restart", a, 1);
    send_byte(8'h01, 1'b0, 1'b0, 1'b0, a);
    send_byte(8'h0C, 1'b0, 1'b1, 1'b1, a);
    bus_stop();
    chk(sw_reg == 8'h55, "R9 partial byte discarded", sw_reg, 8'h55);
    chk(mute_reg == 8'h0C, "R9 write after restart", mute_reg, 8'h0C);

    // R11 single-clock spikes on both lines
    write_reg(8'h00, 8'hE7, 1'b1, "R11 glitch");
    w(40);
    chk(sw_reg == 8'hE7, "R11 value despite spikes", sw_reg, 8'hE7);
    stereo = 1'b1; dual = 1'b0;
    read_status("R11 after glitch");

    w(50);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule